// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status byte that a parallel NOR flash returns while an internal program or erase runs. The command decoder, the timing engine and the storage array sit outside it. They appear here as inputs: the requested operation mode, a launch pulse marking the rising edge of the last write strobe of a command, completion and failure pulses, a reset command, and the array data to return when no status is due. Each read strobe carries an address. Its upper bits pick one of the sectors, and that sector is looked up in an erase-selection mask and a protection mask.

Two toggle bits carry different information. Bit 6 inverts on every status read while any operation is busy, so it tells the host whether the device is working. Bit 2 inverts only on reads that hit a sector selected for erase, both during the erase and while it is suspended. A host therefore reads both bits to learn the mode and which sectors are involved. Bit 5 flags a failed operation. Bits 7, 4, 3, 1 and 0 are always 0. A program aimed at a protected sector produces a short false-busy window and then falls back to array data.

The controller is a five-state machine:
- **ARRAY** is plain read mode.
- **BUSY** means an operation is running.
- **FALSEBUSY** is the protected-program window.
- **SUSP** is erase-suspend read.
- **FAIL** means bit 5 is set.

Transitions:
- **launch-program**: ARRAY→BUSY.
- **launch-erase**: ARRAY→BUSY.
- **launch-protected**: ARRAY or SUSP → FALSEBUSY.
- **window-end**: FALSEBUSY→ARRAY or SUSP.
- **suspend**: BUSY→SUSP.
- **launch-suspend-program**: SUSP→BUSY.
- **resume**: SUSP→BUSY.
- **done**: BUSY→ARRAY or SUSP.
- **fail**: BUSY→FAIL.
- **reset-cmd**: FAIL→ARRAY or SUSP.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is in ARRAY, and a read returns `array_data` one cycle after the strobe, with `rd_valid` high.
- R2: Bit 6 of the returned byte inverts on every status read while in BUSY, FALSEBUSY or FAIL. It never changes on clock cycles without a read strobe.
- R3: On `op_done` during an ordinary program or erase, the block returns to ARRAY, and the next read returns array data.
- R4: A program launched at an address whose sector bit in `sect_prot` is 1 returns toggling status for PROT_CYC = CLK_MHZ*PROT_NS/1000 cycles, then array data. PROT_CYC is 50 at the default values.
- R5: Bit 2 inverts on a status read whose sector (address bits [ADDR_W-1:ADDR_W-SECT_BITS]) is set in `erase_sel`, but only while an erase is running or suspended. On other status reads bit 2 holds its value.
- R6: In SUSP, reads from selected sectors return status with bit 6 steady and bit 2 inverting. Reads from unselected sectors return array data.
- R7: A program launched from SUSP (mode code 4) toggles bit 6 and returns to SUSP on `op_done`.
- R8: `fail_limit` or `fail_zero` during BUSY sets bit 5 in every following status read. Bit 6 keeps toggling until the reset command.
- R9: `reset_cmd` in FAIL returns the block to ARRAY, or to SUSP if the failure happened during a program launched from suspend.
- R10: The status byte has the layout {0, bit6, bit5, 0, 0, bit2, 0, 0}. The toggle bits are 0 after reset.
- R11: The block leaves ARRAY only on `op_go`. A mode value without a launch pulse leaves reads returning array data.
- R12: Mode codes are: 0 idle, 1 program, 2 erase, 3 erase-suspended, 4 program during suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 3 | Operation mode code (R12) |
| op_go | input | 1 | Final write-strobe edge of a command, one cycle |
| go_addr | input | ADDR_W | Target address of the launched command |
| op_done | input | 1 | Operation completed, one cycle |
| fail_limit | input | 1 | Pulse-count limit exceeded, one cycle |
| fail_zero | input | 1 | Program tried to raise a stored 0, one cycle |
| reset_cmd | input | 1 | Reset command, one cycle |
| erase_sel | input | NUM_SECT | Sectors selected for erase |
| sect_prot | input | NUM_SECT | Protected sectors |
| rd_stb | input | 1 | Read strobe, one cycle |
| rd_addr | input | ADDR_W | Read address |
| array_data | input | 8 | Array contents for the read address |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | `rd_data` valid |

## Verification
The hardest situation to reach is a failure during a program launched from erase-suspend. It needs an erase, then a suspend, then a second launch from SUSP, and only then the failure pulse. The failure must leave the erase context intact, so that after the reset command the selected sectors still show a steady bit 6 and an inverting bit 2. The stimulus walks that whole chain in one run, with the toggle bits carried over from earlier phases. Each read is checked against an expected byte built from a running model of both toggle bits.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_ESUSP  = 3'd3,
        OP_ESPROG = 3'd4
    } op_mode_e;

    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_BUSY,
        ST_FALSEBUSY,
        ST_SUSP,
        ST_FAIL
    } fsg_state_e;
endpackage

// File: rtl/fsg_sect_lookup.sv
module fsg_sect_lookup #(
    parameter int ADDR_W    = 12,
    parameter int SECT_BITS = 3,
    localparam int NUM_SECT = 1 << SECT_BITS
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_SECT-1:0] mask,
    output logic                hit
);
    logic [SECT_BITS-1:0] idx;

    assign idx = addr[ADDR_W-1 -: SECT_BITS];
    assign hit = mask[idx];
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (flip) begin
            q <= ~q;
        end
    end
endmodule

// File: rtl/fsg_fsm.sv
module fsg_fsm
    import fsg_pkg::*;
#(
    parameter int PROT_CYC = 50,
    localparam int CNT_W = (PROT_CYC > 1) ? $clog2(PROT_CYC) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] op_mode,
    input  logic       op_go,
    input  logic       go_prot,
    input  logic       op_done,
    input  logic       fail_limit,
    input  logic       fail_zero,
    input  logic       reset_cmd,
    input  logic       rd_stb,
    input  logic       rd_sel,
    output logic       status_rd,
    output logic       flip6,
    output logic       flip2,
    output logic       fail_flag
);
    fsg_state_e st, nxt;
    logic             susp_prog;
    logic             erase_ctx;
    logic [CNT_W-1:0] cnt;
    logic             failed;
    logic             busy_like;

    assign failed = fail_limit | fail_zero;

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_ARRAY: begin
                if (op_go && op_mode == OP_PROG) begin
                    nxt = go_prot ? ST_FALSEBUSY : ST_BUSY;
                end else if (op_go && op_mode == OP_ERASE) begin
                    nxt = ST_BUSY;
                end
            end
            ST_SUSP: begin
                if (op_go && op_mode == OP_ESPROG) begin
                    nxt = go_prot ? ST_FALSEBUSY : ST_BUSY;
                end else if (op_go && op_mode == OP_ERASE) begin
                    nxt = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (failed) begin
                    nxt = ST_FAIL;
                end else if (op_done) begin
                    nxt = susp_prog ? ST_SUSP : ST_ARRAY;
                end else if (erase_ctx && !susp_prog && op_mode == OP_ESUSP) begin
                    nxt = ST_SUSP;
                end
            end
            ST_FALSEBUSY: begin
                if (cnt == '0) begin
                    nxt = susp_prog ? ST_SUSP : ST_ARRAY;
                end
            end
            ST_FAIL: begin
                if (reset_cmd) begin
                    nxt = susp_prog ? ST_SUSP : ST_ARRAY;
                end
            end
            default: nxt = ST_ARRAY;
        endcase
    end

    // state register and context flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_ARRAY;
            susp_prog <= 1'b0;
            erase_ctx <= 1'b0;
            cnt       <= '0;
        end else begin
            st <= nxt;
            if (st == ST_SUSP && op_go && op_mode == OP_ESPROG) begin
                susp_prog <= 1'b1;
            end else if (nxt == ST_SUSP || nxt == ST_ARRAY) begin
                susp_prog <= 1'b0;
            end
            if (st == ST_ARRAY && op_go && op_mode == OP_ERASE) begin
                erase_ctx <= 1'b1;
            end else if (nxt == ST_ARRAY) begin
                erase_ctx <= 1'b0;
            end
            if (nxt == ST_FALSEBUSY && st != ST_FALSEBUSY) begin
                cnt <= CNT_W'(PROT_CYC - 1);
            end else if (st == ST_FALSEBUSY && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy_like = (st == ST_BUSY) || (st == ST_FALSEBUSY) || (st == ST_FAIL);
        status_rd = busy_like || (st == ST_SUSP && rd_sel);
        flip6     = rd_stb && busy_like;
        flip2     = rd_stb && status_rd && erase_ctx && rd_sel;
        fail_flag = (st == ST_FAIL);
    end

    p_leave_array_only_on_go_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARRAY && !op_go) |=> (st == ST_ARRAY));

    p_window_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FALSEBUSY && cnt != '0) |=> (st == ST_FALSEBUSY));

    p_fail_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_FAIL) |-> $past(fail_limit || fail_zero));

    p_fail_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FAIL && !reset_cmd) |=> (st == ST_FAIL));

    p_susp_prog_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUSY && susp_prog && op_done && !failed) |=> (st == ST_SUSP));
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
    parameter int ADDR_W    = 12,
    parameter int SECT_BITS = 3,
    parameter int CLK_MHZ   = 50,
    parameter int PROT_NS   = 1000,
    localparam int NUM_SECT = 1 << SECT_BITS,
    localparam int PROT_CYC = (CLK_MHZ * PROT_NS) / 1000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          op_mode,
    input  logic                op_go,
    input  logic [ADDR_W-1:0]   go_addr,
    input  logic                op_done,
    input  logic                fail_limit,
    input  logic                fail_zero,
    input  logic                reset_cmd,
    input  logic [NUM_SECT-1:0] erase_sel,
    input  logic [NUM_SECT-1:0] sect_prot,
    input  logic                rd_stb,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [7:0]          array_data,
    output logic [7:0]          rd_data,
    output logic                rd_valid
);
    logic rd_sel, go_prot;
    logic status_rd, flip6, flip2, fail_flag;
    logic t6_q, t2_q;

    fsg_sect_lookup #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_rd_sel (
        .addr(rd_addr), .mask(erase_sel), .hit(rd_sel)
    );

    fsg_sect_lookup #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS)) u_go_prot (
        .addr(go_addr), .mask(sect_prot), .hit(go_prot)
    );

    fsg_fsm #(.PROT_CYC(PROT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .op_go(op_go),
        .go_prot(go_prot), .op_done(op_done), .fail_limit(fail_limit),
        .fail_zero(fail_zero), .reset_cmd(reset_cmd), .rd_stb(rd_stb),
        .rd_sel(rd_sel), .status_rd(status_rd), .flip6(flip6),
        .flip2(flip2), .fail_flag(fail_flag)
    );

    fsg_toggle u_t6 (.clk(clk), .rst_n(rst_n), .flip(flip6), .q(t6_q));
    fsg_toggle u_t2 (.clk(clk), .rst_n(rst_n), .flip(flip2), .q(t2_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_stb;
            if (rd_stb) begin
                rd_data <= status_rd ? {1'b0, t6_q, fail_flag, 2'b00, t2_q, 2'b00}
                                     : array_data;
            end
        end
    end

    p_toggles_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ($stable(t6_q) && $stable(t2_q)));

    p_valid_follows_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);
endmodule

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;
    localparam int AW = 12;
    localparam int PROT_CYC = 50;
    localparam logic [7:0] ARR = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] op_mode = 3'd0;
    logic op_go = 1'b0;
    logic [AW-1:0] go_addr = '0;
    logic op_done = 1'b0, fail_limit = 1'b0, fail_zero = 1'b0, reset_cmd = 1'b0;
    logic [7:0] erase_sel = 8'b0000_0110;
    logic [7:0] sect_prot = 8'b1000_0000;
    logic rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0] array_data = ARR;
    logic [7:0] rd_data;
    logic rd_valid;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic e6 = 1'b0, e2 = 1'b0;
    logic [7:0] q_exp[$];
    string q_tag[$];

    always #10 clk = ~clk;

    flash_status_gen dut (
        .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .op_go(op_go),
        .go_addr(go_addr), .op_done(op_done), .fail_limit(fail_limit),
        .fail_zero(fail_zero), .reset_cmd(reset_cmd), .erase_sel(erase_sel),
        .sect_prot(sect_prot), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .array_data(array_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    function automatic logic [AW-1:0] sa(input int s);
        return AW'(s) << (AW - 3);
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (q_exp.size() == 0) begin
                fails++;
                $display("FAIL unexpected read result: actual %h expected none", rd_data);
            end else begin
                logic [7:0] ex;
                string tg;
                ex = q_exp.pop_front();
                tg = q_tag.pop_front();
                if (rd_data !== ex) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", tg, rd_data, ex);
                end
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] ex, input string tg);
        @(negedge clk);
        rd_stb = 1'b1;
        rd_addr = a;
        q_exp.push_back(ex);
        q_tag.push_back(tg);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic rd_st(input int s, input bit f6, input bit f2, input bit fl, input string tg);
        rd(sa(s), {1'b0, e6, fl, 2'b00, e2, 2'b00}, tg);
        if (f6) e6 = ~e6;
        if (f2) e2 = ~e2;
    endtask

    task automatic go(input int s, input logic [2:0] m);
        @(negedge clk);
        op_mode = m;
        go_addr = sa(s);
        op_go = 1'b1;
        @(negedge clk);
        op_go = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: op_done = 1'b1;
            1: fail_zero = 1'b1;
            2: fail_limit = 1'b1;
            default: reset_cmd = 1'b1;
        endcase
        @(negedge clk);
        op_done = 1'b0; fail_zero = 1'b0; fail_limit = 1'b0; reset_cmd = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(sa(0), ARR, "R1 reset array read");
        op_mode = 3'd1;
        rd(sa(0), ARR, "R11 mode without launch");
        // R12 program code 1
        go(0, 3'd1);
        rd_st(0, 1, 0, 0, "R10 first status byte");
        rd_st(0, 1, 0, 0, "R2 toggle");
        repeat (5) @(negedge clk);
        rd_st(0, 1, 0, 0, "R2 idle cycles hold");
        pulse(0);
        rd(sa(0), ARR, "R3 done to array");
        // protected program
        go(7, 3'd1);
        rd_st(7, 1, 0, 0, "R4 window status");
        rd_st(7, 1, 0, 0, "R4 window toggle");
        repeat (PROT_CYC) @(negedge clk);
        rd(sa(7), ARR, "R4 window over");
        // erase
        go(1, 3'd2);
        rd_st(1, 1, 1, 0, "R5 selected sector");
        rd_st(0, 1, 0, 0, "R5 unselected sector");
        rd_st(2, 1, 1, 0, "R5 selected sector 2");
        // suspend
        @(negedge clk);
        op_mode = 3'd3;
        @(negedge clk);
        rd_st(1, 0, 1, 0, "R6 suspended selected");
        rd_st(1, 0, 1, 0, "R6 suspended bit6 steady");
        rd(sa(0), ARR, "R6 suspended unselected");
        // program during suspend
        go(0, 3'd4);
        rd_st(0, 1, 0, 0, "R7 suspend program");
        rd_st(1, 1, 1, 0, "R7 suspend program selected");
        pulse(0);
        rd_st(1, 0, 1, 0, "R7 back to suspend");
        rd(sa(0), ARR, "R7 suspend array read");
        // failure during suspend program
        go(0, 3'd4);
        pulse(1);
        rd_st(0, 1, 0, 1, "R8 zero-to-one failure");
        rd_st(1, 1, 1, 1, "R8 failure toggling");
        pulse(0);
        rd_st(0, 1, 0, 1, "R8 done ignored in fail");
        pulse(3);
        rd(sa(0), ARR, "R9 reset to suspend unselected");
        rd_st(1, 0, 1, 0, "R9 reset to suspend selected");
        // resume, then limit failure
        go(2, 3'd2);
        rd_st(2, 1, 1, 0, "R5 resumed erase");
        pulse(2);
        rd_st(0, 1, 0, 1, "R8 limit failure");
        pulse(3);
        rd(sa(1), ARR, "R9 reset to array");
        go(3, 3'd1);
        rd_st(1, 1, 0, 0, "R5 no erase context");
        pulse(0);
        rd(sa(1), ARR, "R3 program done");
        repeat (3) @(negedge clk);
        if (q_exp.size() != 0) begin
            fails++;
            $display("FAIL missing results: actual %0d pending expected 0", q_exp.size());
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule